// File: doc/BRIEF.md
# Column-Count Multi-Operand Adder and Shift-Add Multiplier

This block adds several unsigned numbers at once by walking their bit columns from the least significant end. In each column it counts the ones among the operand bits and the carries still pending from lower columns. It uses that single count directly: bit 0 of the count is the column's sum bit, bit 1 is a carry into the next column, and bit 2 is a carry two columns up. No chain of full adders is built. A count over five operand bits and two carries never exceeds seven, so those three bits cover every case.

On top of the adder sits an 8x8 shift-and-add multiplier. Each multiplier bit gates a shifted copy of the multiplicand. The first five gated copies go to one adder and the last three to a second adder, and both adders run side by side. One of the adders then sums the two group results in a final pass. The same datapath also offers a plain mode that adds five 8-bit operands.

An operation begins with a one-cycle start pulse. A one-cycle done pulse marks the result after a fixed number of cycles, and the result then holds until the next operation completes.

Top module: `ccm_shift_mul`

## Requirements
- R1: While reset is active and after its release, done is low and result is zero until the first operation completes.
- R2: In add mode (mul_mode low at start) the result is the unsigned sum of the five 8-bit fields of add_ops, where field k occupies bits [8k+7:8k].
- R3: In add mode done rises 20 clock edges after the edge that samples start.
- R4: In multiply mode (mul_mode high at start) the result is the 16-bit unsigned product mcand x mplier.
- R5: In multiply mode done rises 40 clock edges after the edge that samples start. Both group passes finish on the same edge.
- R6: done is high for exactly one cycle per operation, and result keeps its value until the next completion.
- R7: A start pulse that arrives while an operation is in progress is ignored. It produces no extra done and does not change the running result.
- R8: Boundary operands give exact results: five operands of 255 sum to 1275, 255 x 255 gives 65025, and any zero multiplier or multiplicand gives 0.
- R9: After the last column of a pass, no carry is left pending and no result bit lies above the 16-bit product width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an operation when idle |
| mul_mode | input | 1 | 1 = multiply mcand by mplier, 0 = add the five add_ops fields |
| mcand | input | 8 | Multiplicand |
| mplier | input | 8 | Multiplier; bit k gates the copy shifted by k |
| add_ops | input | 40 | Five packed 8-bit addends for add mode |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Sum or product, held until the next completion |

## Verification
An add result is due on the 20th rising edge after start is sampled, and a product on the 40th. Each expected item is queued together with the cycle number on which done must appear. The monitor compares both value and arrival cycle when done is seen, sampling on the falling edge after the register update. Starts issued while busy queue nothing, so any extra done is caught as an item that was never expected. Holding of the result is checked several cycles after done.

// File: rtl/ccm_pkg.sv
// Shared types and helpers for the column-count adder and multiplier.
// Assumes at most five operands per pass, so a column count fits in 3 bits.
package ccm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SUM   = 2'd1,
        PH_GROUP = 2'd2,
        PH_MERGE = 2'd3
    } ccm_phase_e;

    // Bits needed to hold a count of up to n ones.
    function automatic int ccm_cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ccm_col_count.sv
// Ones-counter for one bit column. Counts the operand bits plus the two
// pending carries, and splits the count into the sum bit and two carries.
// Assumes NIN <= 7, so the count never needs more than three bits.
module ccm_col_count #(
    parameter int NIN = 7
) (
    input  logic [NIN-1:0] bits,
    output logic           sum_bit,
    output logic           carry_near,
    output logic           carry_far
);
    import ccm_pkg::*;

    localparam int CW = ccm_cnt_width(NIN);

    logic [CW-1:0] cnt;

    // Population count of the column.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < NIN; i++) begin
            cnt = cnt + CW'(bits[i]);
        end
    end

    // Count bit 0 is the sum, bit 1 goes one column up, bit 2 two columns up.
    always_comb begin
        sum_bit    = cnt[0];
        carry_near = (CW > 1) ? cnt[1 % CW] : 1'b0;
        carry_far  = (CW > 2) ? cnt[2 % CW] : 1'b0;
    end

endmodule

// File: rtl/ccm_col_adder.sv
// Column-serial multi-operand adder. On start it loads NOP operands of W
// bits, then handles one column per cycle, least significant first, for
// W+3 columns. It pulses done together with the (W+3)-bit sum.
// Assumes NOP <= 5. A start seen while busy is not taken.
module ccm_col_adder #(
    parameter int W   = 16,
    parameter int NOP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NOP*W-1:0] ops_flat,
    output logic             done,
    output logic [W+2:0]     sum
);
    localparam int NCOL = W + 3;
    localparam int CLW  = $clog2(NCOL + 1);

    logic [W-1:0]     opnd [NOP];
    logic             busy;
    logic [CLW-1:0]   col;
    logic             c_near;
    logic             c_far_now;
    logic             c_far_next;
    logic [NCOL-1:0]  acc;
    logic             done_q;
    logic [NOP+1:0]   col_bits;
    logic             s_bit;
    logic             k_near;
    logic             k_far;

    // Gather the current column: operand LSBs plus both pending carries.
    always_comb begin
        for (int i = 0; i < NOP; i++) begin
            col_bits[i] = opnd[i][0];
        end
        col_bits[NOP]   = c_near;
        col_bits[NOP+1] = c_far_now;
    end

    ccm_col_count #(.NIN(NOP + 2)) u_cnt (
        .bits       (col_bits),
        .sum_bit    (s_bit),
        .carry_near (k_near),
        .carry_far  (k_far)
    );

    // Load on start, then shift operands and collect one sum bit per column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NOP; i++) opnd[i] <= '0;
            busy       <= 1'b0;
            col        <= '0;
            c_near     <= 1'b0;
            c_far_now  <= 1'b0;
            c_far_next <= 1'b0;
            acc        <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy) begin
                for (int i = 0; i < NOP; i++) opnd[i] <= opnd[i] >> 1;
                acc        <= {s_bit, acc[NCOL-1:1]};
                c_near     <= k_near;
                c_far_now  <= c_far_next;
                c_far_next <= k_far;
                col        <= col + 1'b1;
                if (col == CLW'(NCOL - 1)) begin
                    busy   <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (start) begin
                for (int i = 0; i < NOP; i++) opnd[i] <= ops_flat[i*W +: W];
                acc        <= '0;
                c_near     <= 1'b0;
                c_far_now  <= 1'b0;
                c_far_next <= 1'b0;
                col        <= '0;
                busy       <= 1'b1;
            end
        end
    end

    assign done = done_q;
    assign sum  = acc;

    // Reference total of the loaded operands, kept for checking only.
    logic [NCOL-1:0] in_total;
    logic [NCOL-1:0] ref_total;

    always_comb begin
        in_total = '0;
        for (int i = 0; i < NOP; i++) in_total = in_total + NCOL'(ops_flat[i*W +: W]);
    end

    // Capture the reference when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)             ref_total <= '0;
        else if (!busy && start) ref_total <= in_total;
    end

    // R2
    adder_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> acc == ref_total);

    // R9
    no_carry_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!c_near && !c_far_now && !c_far_next));

    // R6
    adder_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/ccm_pp_gen.sv
// Partial-product generator: copy k is the multiplicand shifted left by k,
// kept only when multiplier bit k is set. All copies are 2*W bits wide.
module ccm_pp_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0]       mcand,
    input  logic [W-1:0]       mplier,
    output logic [W*2*W-1:0]   pp_flat
);
    localparam int PW = 2 * W;

    for (genvar k = 0; k < W; k++) begin : g_pp
        // Gate and shift one copy.
        assign pp_flat[k*PW +: PW] = mplier[k] ? (PW'(mcand) << k) : '0;
    end

endmodule

// File: rtl/ccm_shift_mul.sv
// Top level: five-operand adder mode and an OPW x OPW shift-and-add multiply.
// Multiply runs a group pass (copies 0..NGRP-1 on adder A, the rest on
// adder B, in parallel), then a merge pass on adder A that sums both group
// totals. Add mode uses a single pass on adder A.
// Assumes 2 <= NGRP <= 5 and NGRP < OPW <= 2*NGRP. Start is taken only when idle.
module ccm_shift_mul #(
    parameter int OPW  = 8,
    parameter int NGRP = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mul_mode,
    input  logic [OPW-1:0]      mcand,
    input  logic [OPW-1:0]      mplier,
    input  logic [NGRP*OPW-1:0] add_ops,
    output logic                done,
    output logic [2*OPW-1:0]    result
);
    import ccm_pkg::*;

    localparam int PW = 2 * OPW;
    localparam int NB = OPW - NGRP;
    localparam int RW = PW + 3;

    ccm_phase_e         phase;
    logic [OPW*PW-1:0]  pp_flat;
    logic [NGRP*PW-1:0] add_x;
    logic [NGRP*PW-1:0] grp_b_ops;
    logic [NGRP*PW-1:0] merge_ops;
    logic [NGRP*PW-1:0] ops_a;
    logic               accept;
    logic               merge_go;
    logic               start_a;
    logic               start_b;
    logic               done_a;
    logic               done_b;
    logic [RW-1:0]      res_a;
    logic [RW-1:0]      res_b;
    logic               done_q;
    logic [PW-1:0]      result_q;

    ccm_pp_gen #(.W(OPW)) u_pp (
        .mcand   (mcand),
        .mplier  (mplier),
        .pp_flat (pp_flat)
    );

    for (genvar k = 0; k < NGRP; k++) begin : g_slots
        // Widen each addend to the product width.
        assign add_x[k*PW +: PW] = PW'(add_ops[k*OPW +: OPW]);
        // Second group takes the upper copies; unused slots stay zero.
        if (k < NB) begin : g_b_used
            assign grp_b_ops[k*PW +: PW] = pp_flat[(NGRP+k)*PW +: PW];
        end else begin : g_b_zero
            assign grp_b_ops[k*PW +: PW] = '0;
        end
    end

    assign merge_ops = {{((NGRP-2)*PW){1'b0}}, res_b[PW-1:0], res_a[PW-1:0]};

    // Start handshake and operand selection for both adders.
    always_comb begin
        accept   = start && (phase == PH_IDLE);
        merge_go = done_a && (phase == PH_GROUP);
        start_a  = accept || merge_go;
        start_b  = accept && mul_mode;
        if (phase == PH_GROUP) ops_a = merge_ops;
        else if (mul_mode)     ops_a = pp_flat[NGRP*PW-1:0];
        else                   ops_a = add_x;
    end

    ccm_col_adder #(.W(PW), .NOP(NGRP)) u_add_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_a),
        .ops_flat (ops_a),
        .done     (done_a),
        .sum      (res_a)
    );

    ccm_col_adder #(.W(PW), .NOP(NGRP)) u_add_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_b),
        .ops_flat (grp_b_ops),
        .done     (done_b),
        .sum      (res_b)
    );

    // Phase sequencing and registering of the final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE:  if (accept) phase <= mul_mode ? PH_GROUP : PH_SUM;
                PH_GROUP: if (done_a) phase <= PH_MERGE;
                PH_SUM, PH_MERGE: begin
                    if (done_a) begin
                        phase    <= PH_IDLE;
                        done_q   <= 1'b1;
                        result_q <= res_a[PW-1:0];
                    end
                end
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assign done   = done_q;
    assign result = result_q;

    // Operands of the accepted operation, kept for checking only.
    logic           sh_mul;
    logic [PW-1:0]  sh_prod;
    logic [PW-1:0]  sh_sum;
    logic [PW-1:0]  in_sum;

    always_comb begin
        in_sum = '0;
        for (int k = 0; k < NGRP; k++) in_sum = in_sum + add_x[k*PW +: PW];
    end

    // Capture expected values on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mul  <= 1'b0;
            sh_prod <= '0;
            sh_sum  <= '0;
        end else if (accept) begin
            sh_mul  <= mul_mode;
            sh_prod <= PW'(mcand) * PW'(mplier);
            sh_sum  <= in_sum;
        end
    end

    // R4
    product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && sh_mul) |-> result_q == sh_prod);

    // R2
    add_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !sh_mul) |-> result_q == sh_sum);

    // R5
    groups_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_GROUP && done_a) |-> (done_b && res_b[RW-1:PW] == '0));

    // R9
    width_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_a |-> res_a[RW-1:PW] == '0);

    // R6
    top_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: tb/ccm_shift_mul_tb.sv
module ccm_shift_mul_tb;

    localparam int LAT_ADD = 20;
    localparam int LAT_MUL = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mul_mode = 1'b0;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic [39:0] ops_in = '0;
    logic        done;
    logic [15:0] result;

    ccm_shift_mul u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mul_mode (mul_mode),
        .mcand    (a_in),
        .mplier   (b_in),
        .add_ops  (ops_in),
        .done     (done),
        .result   (result)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [15:0] val;
        int          due;
        string       vtag;
        string       ltag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic prev_done = 1'b0;
    bit   finished = 0;
    logic [31:0] rng = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Monitor: pops the scoreboard on every done and compares value and cycle.
    always @(negedge clk) begin
        exp_t it;
        if (rst_n && done) begin
            if (prev_done) check(1'b0, "R6", "done longer than one cycle", 1, 0);
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                it = sb.pop_front();
                check(result == it.val, it.vtag, "result", result, it.val);
                check(cyc == it.due, it.ltag, "done cycle", cyc, it.due);
            end
        end
        prev_done <= done;
    end

    // Driver: issues one operation, queues its expectation, waits for it.
    task automatic issue(input bit m, input logic [7:0] x, input logic [7:0] y,
                         input logic [39:0] ops, input string vtag);
        exp_t it;
        int   s;
        @(negedge clk);
        start = 1'b1; mul_mode = m; a_in = x; b_in = y; ops_in = ops;
        s = 0;
        for (int k = 0; k < 5; k++) s += int'(ops[k*8 +: 8]);
        it.val  = m ? 16'(int'(x) * int'(y)) : 16'(s);
        it.due  = cyc + 1 + (m ? LAT_MUL : LAT_ADD);
        it.vtag = vtag;
        it.ltag = m ? "R5" : "R3";
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        repeat (m ? LAT_MUL : LAT_ADD) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(result == 16'd0, "R1", "result in reset", result, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && result == 16'd0, "R1", "idle after reset", result, 0);

        // R2 / R8: add corners
        issue(1'b0, 8'd0, 8'd0, 40'h0, "R2");
        issue(1'b0, 8'd0, 8'd0, {5{8'hFF}}, "R8");
        issue(1'b0, 8'd0, 8'd0, 40'h01_02_03_04_05, "R2");
        issue(1'b0, 8'd0, 8'd0, 40'h80_80_80_80_80, "R2");
        issue(1'b0, 8'd0, 8'd0, 40'h00_00_00_00_FF, "R2");

        // R2: pseudo-random sums
        for (int i = 0; i < 300; i++) begin
            logic [39:0] v;
            rng = next_rng(rng); v[31:0] = rng;
            rng = next_rng(rng); v[39:32] = rng[7:0];
            issue(1'b0, 8'd0, 8'd0, v, "R2");
        end

        // R8: multiply corners
        issue(1'b1, 8'd255, 8'd255, 40'h0, "R8");
        issue(1'b1, 8'd0, 8'd173, 40'h0, "R8");
        issue(1'b1, 8'd173, 8'd0, 40'h0, "R8");

        // R4: sweep of multiplier against chosen multiplicands
        for (int i = 0; i < 10; i++) begin
            logic [7:0] av;
            case (i)
                0: av = 8'd1;   1: av = 8'd2;   2: av = 8'd3;   3: av = 8'd85;
                4: av = 8'd127; 5: av = 8'd128; 6: av = 8'd170; 7: av = 8'd254;
                8: av = 8'd255; default: av = 8'd99;
            endcase
            for (int j = 0; j < 256; j++) issue(1'b1, av, 8'(j), 40'h0, "R4");
        end

        // R6: result holds after done
        issue(1'b1, 8'd201, 8'd77, 40'h0, "R4");
        repeat (6) @(negedge clk);
        check(result == 16'(201 * 77), "R6", "result hold", result, 201 * 77);
        check(done == 1'b0, "R6", "done low after pulse", done, 0);

        // R7: start pulses during a running multiply are ignored
        fork
            issue(1'b1, 8'd19, 8'd233, 40'h0, "R7");
            begin
                repeat (6) @(negedge clk);
                start = 1'b1; mul_mode = 1'b0; ops_in = {5{8'h11}};
                @(negedge clk); start = 1'b0;
                repeat (20) @(negedge clk);
                start = 1'b1; mul_mode = 1'b1; a_in = 8'd3; b_in = 8'd3;
                @(negedge clk); start = 1'b0;
            end
        join
        repeat (45) @(negedge clk);
        check(sb.size() == 0, "R7", "pending items after busy starts", sb.size(), 0);
        check(result == 16'(19 * 233), "R7", "result after busy starts", result, 19 * 233);

        // R7: same during an add pass
        fork
            issue(1'b0, 8'd0, 8'd0, 40'h10_20_30_40_50, "R7");
            begin
                repeat (4) @(negedge clk);
                start = 1'b1; mul_mode = 1'b1; a_in = 8'd200; b_in = 8'd200;
                @(negedge clk); start = 1'b0;
            end
        join
        repeat (45) @(negedge clk);
        check(sb.size() == 0, "R7", "pending items after add busy start", sb.size(), 0);
        check(result == 16'd240, "R7", "add result after busy start", result, 240);

        finish_run();
    end

endmodule